// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block counts out a CRT-style raster. A dot-clock enable advances a horizontal dot position; at the end of each line the line count steps, and at the end of the last line it wraps to zero. In interlaced operation the field flag inverts at every wrap. A single-cycle frame-start pulse, together with a frame counter, marks the line on which the visible frame begins. The block also raises a vertical blanking flag over a retrace window that it derives from the programmed line total.

Software programs four registers through simple write and read strobes. These are the packed line and dot totals, the sync timing (vsync line count and hsync width), a sync configuration word holding the interlace switch, and the front and back porch lengths. A live status word is built combinationally from the counters. It reports the current line and field, and it gives display-active and sync-off flags under different rules for lines of each parity.

Top module: `vid_raster_timer`

## Requirements
- R1: The geometry register (address 0) stores lines-minus-one in bits 25:16 and dots-per-line-minus-one in bits 9:0. Writes are masked with 0x03FF03FF, and the reset value is 0x0270035F (625 lines of 864 dots).
- R2: The dot position advances only on a cycle with `dot_en` high. From dots-minus-one it returns to 0, and the line count then advances.
- R3: After the last line the line count returns to 0. At that point `field_odd` inverts only when interlace (bit 4 of the sync configuration register, address 2) is set. Writes to address 2 are masked to bits 9:0.
- R4: When the line count steps onto RETRACE_END, `frame_start` is high for exactly one cycle and `frame_count` increments by one. Both take effect at the same edge as the line change.
- R5: `vblank` is high when the line is below RETRACE_END, or at or above lines-total minus RETRACE_GAP.
- R6: The sync timing register (address 1) has reset value 0x07D6A53F. Writes clear bit 7. Bits 11:8 give the vsync line count, and bits 6:0 give the hsync width in units of two dots minus one, so the width in dots is (field+1)*2.
- R7: Status bits 9:0 carry the line and bit 10 carries the field (1 = odd). Bit 11 means display active, bit 12 means hsync off and bit 13 means vsync off. Bits above 13 read as 0.
- R8: On a line whose bit 0 equals the field flag, bit 12 is set while the dot is greater than the hsync width. At or after the vsync line count, such a line adds 0x2800 while the dot is greater than the front porch, and 0x2000 otherwise.
- R9: On any other line at or after the vsync line count, status adds 0x3800 while dot + back porch is less than dots per line, and 0x1000 otherwise. Below the vsync line count it adds nothing.
- R10: A write to the geometry register clears the dot position, the line count and the field flag at the same edge.
- R11: The porch register (address 3) holds the front porch in bits 9:0 and the back porch in bits 25:16, with writes masked by 0x03FF03FF. At reset the back porch is DOT_CLK_KHZ*4/1000 dots and the front porch is FP_RESET.
- R12: `rd_data` is combinational on `rd_addr`: addresses 0 to 3 return the stored registers, address 4 returns the status word and every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable, one dot per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data |
| status | output | 14 | Live sync status word |
| dot_pos | output | 10 | Current dot position |
| line_num | output | 10 | Current line count |
| field_odd | output | 1 | Field flag, 1 = odd |
| vblank | output | 1 | Retrace window flag |
| frame_start | output | 1 | One-cycle pulse on entering the first displayed line |
| frame_count | output | FC_W | Frame counter |

## Verification
All of the state in this block is visible through its outputs. A wrong dot or line count shows on `dot_pos` and `line_num`, and through them in status bits 9:0, in the very cycle after the faulty edge. A lost field toggle flips the parity rule in status bits 11 to 13 on every following line. A bad wrap or retrace comparison misplaces `frame_start` and makes `frame_count` drift within one frame of a small geometry. The bench computes every expected value from the number of enabled dots since the last geometry write, so any error becomes visible within one line.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   localparam int LINE_W = 10;
   localparam int DOT_W  = 10;
   localparam int ST_W   = 14;

   localparam int ST_FIELD  = 10;
   localparam int ST_ACTIVE = 11;
   localparam int ST_HS_OFF = 12;
   localparam int ST_VS_OFF = 13;

   localparam int NUM_RW = 4;

   typedef enum logic [2:0] {
      VRT_GEOM   = 3'd0,
      VRT_SYNC   = 3'd1,
      VRT_CFG    = 3'd2,
      VRT_PORCH  = 3'd3,
      VRT_STATUS = 3'd4
   } vrt_addr_e;

   localparam logic [31:0] MASK_GEOM  = 32'h03FF_03FF;
   localparam logic [31:0] MASK_SYNC  = 32'hFFFF_FF7F;
   localparam logic [31:0] MASK_CFG   = 32'h0000_03FF;
   localparam logic [31:0] MASK_PORCH = 32'h03FF_03FF;

   function automatic logic [31:0] reg_mask(input int idx);
      case (idx)
         0:       return MASK_GEOM;
         1:       return MASK_SYNC;
         2:       return MASK_CFG;
         default: return MASK_PORCH;
      endcase
   endfunction

endpackage

// File: rtl/vrt_regs.sv
module vrt_regs
   import vrt_pkg::*;
#(
   parameter logic [31:0] RST_GEOM  = 32'h0270_035F,
   parameter logic [31:0] RST_SYNC  = 32'h07D6_A53F,
   parameter logic [31:0] RST_CFG   = 32'h0000_0000,
   parameter logic [31:0] RST_PORCH = 32'h0000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [2:0]         rd_addr,
   input  logic [ST_W-1:0]    status,
   output logic [31:0]        rd_data,
   output logic               geom_wr,
   output logic [DOT_W-1:0]   dot_max,
   output logic [LINE_W-1:0]  line_max,
   output logic [3:0]         vs_lines,
   output logic [6:0]         hs_units,
   output logic               interlace,
   output logic [DOT_W-1:0]   front_porch,
   output logic [DOT_W-1:0]   back_porch
);

   localparam logic [31:0] RST_ARR [NUM_RW] = '{RST_GEOM, RST_SYNC, RST_CFG, RST_PORCH};

   logic [31:0] reg_q [NUM_RW];

   for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
      localparam logic [31:0] MSK = reg_mask(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q[g] <= RST_ARR[g] & MSK;
         else if (wr_en && (wr_addr == 3'(g)))
            reg_q[g] <= wr_data & MSK;
      end
   end

   assign geom_wr     = wr_en && (wr_addr == VRT_GEOM);
   assign dot_max     = reg_q[0][DOT_W-1:0];
   assign line_max    = reg_q[0][16 +: LINE_W];
   assign vs_lines    = reg_q[1][11:8];
   assign hs_units    = reg_q[1][6:0];
   assign interlace   = reg_q[2][4];
   assign front_porch = reg_q[3][DOT_W-1:0];
   assign back_porch  = reg_q[3][16 +: DOT_W];

   always_comb begin
      rd_data = '0;
      if (rd_addr < 3'(NUM_RW))
         rd_data = reg_q[rd_addr[1:0]];
      else if (rd_addr == VRT_STATUS)
         rd_data = {{(32-ST_W){1'b0}}, status};
   end

endmodule

// File: rtl/vrt_counter.sv
module vrt_counter
   import vrt_pkg::*;
#(
   parameter int FC_W        = 16,
   parameter int RETRACE_END = 42
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dot_en,
   input  logic               geom_wr,
   input  logic [DOT_W-1:0]   dot_max,
   input  logic [LINE_W-1:0]  line_max,
   input  logic               interlace,
   output logic [DOT_W-1:0]   dot_q,
   output logic [LINE_W-1:0]  line_q,
   output logic               field_q,
   output logic               fs_q,
   output logic [FC_W-1:0]    fc_q
);

   localparam logic [LINE_W-1:0] RE_LINE = LINE_W'(RETRACE_END);

   logic              dot_last;
   logic              line_last;
   logic [LINE_W-1:0] line_nxt;

   assign dot_last  = (dot_q == dot_max);
   assign line_last = (line_q == line_max);
   assign line_nxt  = line_last ? '0 : line_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dot_q   <= '0;
         line_q  <= '0;
         field_q <= 1'b0;
         fs_q    <= 1'b0;
         fc_q    <= '0;
      end else begin
         fs_q <= 1'b0;
         if (geom_wr) begin
            dot_q   <= '0;
            line_q  <= '0;
            field_q <= 1'b0;
         end else if (dot_en) begin
            if (dot_last) begin
               dot_q  <= '0;
               line_q <= line_nxt;
               if (line_last && interlace)
                  field_q <= ~field_q;
               if (line_nxt == RE_LINE) begin
                  fs_q <= 1'b1;
                  fc_q <= fc_q + 1'b1;
               end
            end else begin
               dot_q <= dot_q + 1'b1;
            end
         end
      end
   end

   AST_DOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dot_q <= dot_max); // R2
   AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      line_q <= line_max); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!dot_en && !geom_wr) |=> ($stable(dot_q) && $stable(line_q))); // R2
   AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!interlace && !geom_wr) |=> $stable(field_q)); // R3
   AST_FRAME_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |-> (line_q == RE_LINE)); // R4
   AST_FRAME_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |-> (fc_q == FC_W'($past(fc_q) + 1'b1))); // R4
   AST_GEOM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      geom_wr |=> (dot_q == '0 && line_q == '0 && !field_q)); // R10

endmodule

// File: rtl/vrt_status.sv
module vrt_status
   import vrt_pkg::*;
#(
   parameter int RETRACE_END = 42,
   parameter int RETRACE_GAP = 6
) (
   input  logic [DOT_W-1:0]   dot,
   input  logic [LINE_W-1:0]  line,
   input  logic               field,
   input  logic [DOT_W-1:0]   dot_max,
   input  logic [LINE_W-1:0]  line_max,
   input  logic [3:0]         vs_lines,
   input  logic [6:0]         hs_units,
   input  logic [DOT_W-1:0]   front_porch,
   input  logic [DOT_W-1:0]   back_porch,
   output logic [ST_W-1:0]    status,
   output logic               vblank
);

   logic [DOT_W-1:0] hs_dots;
   logic             parity_match;
   logic             past_vs;
   logic [DOT_W:0]   dots_total;
   logic [DOT_W:0]   dot_plus_bp;
   logic             before_bp;
   logic [LINE_W:0]  line_plus_gap;

   assign hs_dots       = {2'b00, hs_units, 1'b0} + DOT_W'(2);
   assign parity_match  = (line[0] == field);
   assign past_vs       = (line >= {{(LINE_W-4){1'b0}}, vs_lines});
   assign dots_total    = {1'b0, dot_max} + 1'b1;
   assign dot_plus_bp   = {1'b0, dot} + {1'b0, back_porch};
   assign before_bp     = (dot_plus_bp < dots_total);
   assign line_plus_gap = {1'b0, line} + (LINE_W+1)'(RETRACE_GAP);

   assign vblank = (line_plus_gap > {1'b0, line_max}) || (line < LINE_W'(RETRACE_END));

   always_comb begin
      status = '0;
      status[LINE_W-1:0] = line;
      status[ST_FIELD]   = field;
      if (parity_match) begin
         if (dot > hs_dots)
            status[ST_HS_OFF] = 1'b1;
         if (past_vs) begin
            status[ST_VS_OFF] = 1'b1;
            if (dot > front_porch)
               status[ST_ACTIVE] = 1'b1;
         end
      end else if (past_vs) begin
         status[ST_HS_OFF] = 1'b1;
         if (before_bp) begin
            status[ST_VS_OFF] = 1'b1;
            status[ST_ACTIVE] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/vid_raster_timer.sv
module vid_raster_timer
   import vrt_pkg::*;
#(
   parameter int          DOT_CLK_KHZ = 27000,
   parameter int          FC_W        = 16,
   parameter int          RETRACE_END = 42,
   parameter int          RETRACE_GAP = 6,
   parameter int          FP_RESET    = 0,
   parameter logic [31:0] RST_GEOM    = 32'h0270_035F,
   parameter logic [31:0] RST_SYNC    = 32'h07D6_A53F,
   parameter logic [31:0] RST_CFG     = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic [13:0]       status,
   output logic [9:0]        dot_pos,
   output logic [9:0]        line_num,
   output logic              field_odd,
   output logic              vblank,
   output logic              frame_start,
   output logic [FC_W-1:0]   frame_count
);

   localparam int          BP_RESET  = DOT_CLK_KHZ * 4 / 1000;
   localparam logic [31:0] RST_PORCH = (32'(BP_RESET) << 16) | 32'(FP_RESET);

   initial begin
      assert (FC_W >= 1 && FC_W <= 32) else $error("FC_W out of range");
      assert (RETRACE_END >= 0 && RETRACE_END < (1 << LINE_W)) else $error("RETRACE_END too large");
      assert (RETRACE_GAP >= 0 && RETRACE_GAP < (1 << LINE_W)) else $error("RETRACE_GAP too large");
      assert (BP_RESET < (1 << DOT_W)) else $error("back porch reset too large");
      assert (FP_RESET >= 0 && FP_RESET < (1 << DOT_W)) else $error("front porch reset too large");
   end

   logic              geom_wr;
   logic [DOT_W-1:0]  dot_max;
   logic [LINE_W-1:0] line_max;
   logic [3:0]        vs_lines;
   logic [6:0]        hs_units;
   logic              interlace;
   logic [DOT_W-1:0]  front_porch;
   logic [DOT_W-1:0]  back_porch;
   logic [ST_W-1:0]   status_w;

   vrt_regs #(
      .RST_GEOM  (RST_GEOM),
      .RST_SYNC  (RST_SYNC),
      .RST_CFG   (RST_CFG),
      .RST_PORCH (RST_PORCH)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .status      (status_w),
      .rd_data     (rd_data),
      .geom_wr     (geom_wr),
      .dot_max     (dot_max),
      .line_max    (line_max),
      .vs_lines    (vs_lines),
      .hs_units    (hs_units),
      .interlace   (interlace),
      .front_porch (front_porch),
      .back_porch  (back_porch)
   );

   vrt_counter #(
      .FC_W        (FC_W),
      .RETRACE_END (RETRACE_END)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .dot_en    (dot_en),
      .geom_wr   (geom_wr),
      .dot_max   (dot_max),
      .line_max  (line_max),
      .interlace (interlace),
      .dot_q     (dot_pos),
      .line_q    (line_num),
      .field_q   (field_odd),
      .fs_q      (frame_start),
      .fc_q      (frame_count)
   );

   vrt_status #(
      .RETRACE_END (RETRACE_END),
      .RETRACE_GAP (RETRACE_GAP)
   ) u_stat (
      .dot         (dot_pos),
      .line        (line_num),
      .field       (field_odd),
      .dot_max     (dot_max),
      .line_max    (line_max),
      .vs_lines    (vs_lines),
      .hs_units    (hs_units),
      .front_porch (front_porch),
      .back_porch  (back_porch),
      .status      (status_w),
      .vblank      (vblank)
   );

   assign status = status_w;

   AST_ACTIVE_HAS_VS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_ACTIVE] |-> status[ST_VS_OFF]); // R8

endmodule

// File: tb/sim_vid_raster_timer.sv
module sim_vid_raster_timer;

   localparam int D  = 20;
   localparam int L  = 12;
   localparam int RE = 4;
   localparam int GAP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dot_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [13:0] status;
   logic [9:0]  dot_pos;
   logic [9:0]  line_num;
   logic        field_odd;
   logic        vblank;
   logic        frame_start;
   logic [15:0] frame_count;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   vid_raster_timer #(.RETRACE_END(RE), .RETRACE_GAP(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .status(status), .dot_pos(dot_pos),
      .line_num(line_num), .field_odd(field_odd), .vblank(vblank),
      .frame_start(frame_start), .frame_count(frame_count)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input bit en);
      dot_en = en;
      @(posedge clk);
      #1;
      dot_en = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [13:0] exp_status(int line, int dot, int fld,
                                              int vs, int hsd, int fp, int bp);
      logic [13:0] s;
      s = 14'(line) | (14'(fld) << 10);
      if ((line % 2) == fld) begin
         if (dot > hsd) s = s | 14'h1000;
         if (line >= vs) s = s | ((dot > fp) ? 14'h2800 : 14'h2000);
      end else if (line >= vs) begin
         s = s | ((dot + bp < D) ? 14'h3800 : 14'h1000);
      end
      return s;
   endfunction

   task automatic sweep(input int cycles, input int gap_every, input bit interl,
                        input int fp, input int bp);
      int n;
      int fcb;
      n = 0;
      fcb = int'(frame_count);
      for (int i = 0; i < cycles; i++) begin
         bit en;
         int lines, dot, line, fld, fc, k0;
         bit fs, vb;
         en = (gap_every == 0) ? 1'b1 : ((i % gap_every) != gap_every - 1);
         tick(en);
         if (en) n++;
         lines = n / D;
         dot   = n % D;
         line  = lines % L;
         fld   = interl ? ((lines / L) % 2) : 0;
         k0    = (RE == 0) ? L : RE;
         fc    = fcb + ((lines >= k0) ? ((lines - k0) / L + 1) : 0);
         fs    = en && (dot == 0) && (line == RE) && (n > 0);
         vb    = (line + GAP > L - 1) || (line < RE);
         chk("R2 dot position", 32'(dot_pos), 32'(dot));
         chk("R3 line wrap", 32'(line_num), 32'(line));
         chk("R3 field flag", 32'(field_odd), 32'(fld));
         chk("R4 frame_start", 32'(frame_start), 32'(fs));
         chk("R4 frame_count", 32'(frame_count), 32'(fc & 16'hFFFF));
         chk("R5 vblank", 32'(vblank), 32'(vb));
         chk("R8 R9 status", 32'(status), 32'(exp_status(line, dot, fld, 2, 6, fp, bp)));
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // reset state
      chk("R2 reset dot", 32'(dot_pos), 0);
      chk("R3 reset line", 32'(line_num), 0);
      chk("R4 reset frame_count", 32'(frame_count), 0);
      chk("R5 reset vblank", 32'(vblank), 1);
      chk("R7 reset status", 32'(status), 0);
      rd(3'd0, d); chk("R1 geometry reset", d, 32'h0270_035F);
      rd(3'd1, d); chk("R6 sync reset", d, 32'h07D6_A53F);
      rd(3'd2, d); chk("R3 cfg reset", d, 0);
      rd(3'd3, d); chk("R11 porch reset", d, 32'h006C_0000);
      rd(3'd4, d); chk("R12 status readback", d, 0);

      // write masks
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R1 geometry mask", d, 32'h03FF_03FF);
      wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R6 sync mask", d, 32'hFFFF_FF7F);
      wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R3 cfg mask", d, 32'h0000_03FF);
      wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R11 porch mask", d, 32'h03FF_03FF);
      rd(3'd5, d); chk("R12 unmapped 5", d, 0);
      rd(3'd7, d); chk("R12 unmapped 7", d, 0);

      // counter advances only with enable, then geometry write clears it
      for (int i = 0; i < 30; i++) tick(1'b1);
      for (int i = 0; i < 5; i++) tick(1'b0);
      chk("R2 enable gating", 32'(dot_pos), 30);
      wr(3'd2, 32'h0);
      wr(3'd1, 32'h0000_0282);
      rd(3'd1, d); chk("R6 bit7 cleared", d, 32'h0000_0202);
      wr(3'd3, (32'd5 << 16) | 32'd8);
      rd(3'd3, d); chk("R11 porch fields", d, 32'h0005_0008);
      wr(3'd0, (32'(L - 1) << 16) | 32'(D - 1));
      chk("R10 clear dot", 32'(dot_pos), 0);
      chk("R10 clear line", 32'(line_num), 0);
      rd(3'd4, d); chk("R12 status via read port", d, 32'(status));

      // progressive sweep with gaps in the dot enable
      sweep(1200, 3, 1'b0, 8, 5);

      // interlaced sweep with other porches
      wr(3'd2, 32'h0000_0010);
      wr(3'd3, (32'd12 << 16) | 32'd3);
      wr(3'd0, (32'(L - 1) << 16) | 32'(D - 1));
      chk("R10 clear field", 32'(field_odd), 0);
      sweep(2000, 0, 1'b1, 3, 12);

      // geometry write mid-frame clears field and position
      for (int i = 0; i < 7; i++) tick(1'b1);
      wr(3'd0, (32'(L - 1) << 16) | 32'(D - 1));
      chk("R10 mid-run clear dot", 32'(dot_pos), 0);
      chk("R10 mid-run clear line", 32'(line_num), 0);
      chk("R10 mid-run clear field", 32'(field_odd), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule